// File: doc/BRIEF.md
# Two-Register Operand Stack Cache

This block is the operand-stack core of a small stack processor. The two topmost stack entries sit in registers: `tos` holds the top of stack and `nos` the entry right beneath it. Together they form the two operands that an external ALU reads. All deeper entries are spilled into a stack RAM that is modelled inside the block as a register array. A pointer `sp` always addresses the third entry from the top. Every push or pop moves one word between `nos` and the RAM in the same clock cycle.

Each cycle, the surrounding decode logic presents a 3-bit command. The command pushes an external value, pops, duplicates the top, replaces the top with a unary ALU result, folds the two top entries into a binary ALU result, or holds. The RAM has one write port and one read port. A spill to `sp+1` and a refill from `sp` can therefore happen in the same cycle. The block exposes the RAM port signals so that their behaviour can be observed.

After reset, `sp` holds its all-ones empty value, so the first spill lands at address 0. A command that would grow the stack past the last usable RAM slot is refused. A command that would refill `nos` from an empty RAM is also refused. Each refusal raises a one-cycle error flag.

Top module: `stk_cache_core`

## Requirements
- R1: After synchronous reset, `tos` and `nos` are 0, `sp` is all ones (255 with the defaults), `ovf` and `unf` are 0, and `ram_we` is low while the command is hold.
- R2: Command 1 (push), when not full: at the next edge `tos` takes `push_data`, `nos` takes the old `tos`, and `sp` increments. In the command cycle, `ram_we` is 1, `ram_waddr` is `sp+1` and `ram_wdata` is the old `nos`.
- R3: Command 2 (pop), when not empty: at the next edge `tos` takes the old `nos`, `nos` takes the RAM word at `sp`, and `sp` decrements. No RAM write happens.
- R4: Command 3 (duplicate), when not full: `tos` keeps its value, `nos` takes `tos`, the old `nos` is written to `sp+1`, and `sp` increments.
- R5: Command 4 (unary): `tos` takes `alu_result`, while `nos` and `sp` are unchanged. No RAM write happens.
- R6: Command 5 (binary), when not empty: `tos` takes `alu_result`, `nos` takes the RAM word at `sp`, and `sp` decrements.
- R7: Command 0 (hold), and the unused codes 6 and 7, leave `tos`, `nos` and `sp` unchanged and do not write the RAM.
- R8: Push or duplicate while `sp` equals DEPTH-2 (the full state, 254 with the defaults) writes nothing and changes no state. `ovf` is 1 for exactly the following cycle.
- R9: Pop or binary while `sp` is all ones (empty) changes no state. `unf` is 1 for exactly the following cycle. `ovf` and `unf` are 0 after any accepted or hold command.
- R10: `ram_raddr` equals `sp` in every cycle. Words spilled to the RAM return to `nos` in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Stack command: 0 hold, 1 push, 2 pop, 3 duplicate, 4 unary, 5 binary |
| push_data | input | 16 | Value loaded into the top entry by a push |
| alu_result | input | 16 | ALU result used by the unary and binary commands |
| tos | output | 16 | Top-of-stack register |
| nos | output | 16 | Register holding the entry below the top |
| sp | output | 8 | Pointer to the third entry in the stack RAM |
| ovf | output | 1 | One-cycle pulse after a refused push or duplicate |
| unf | output | 1 | One-cycle pulse after a refused pop or binary |
| ram_we | output | 1 | Stack RAM write enable for this cycle |
| ram_waddr | output | 8 | Stack RAM write address |
| ram_wdata | output | 16 | Stack RAM write data |
| ram_raddr | output | 8 | Stack RAM read address |

## Verification
A wrong pointer does not stay hidden. It shows at `sp` and `ram_raddr` in the very next cycle, and it shows again at `nos` at the first refill that reads the wrong slot, which may come many commands later. A lost or misplaced spill therefore surfaces only when the stack is unwound. For this reason the stimulus drives the stack to full depth and back down, so that every spilled word is checked on its way back. Wrong register steering or a wrong full/empty decision is visible at `tos`, `nos`, `ovf` or `unf` one edge after the command. The write-port outputs reveal it in the command cycle itself.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_HOLD   = 3'd0,
        CMD_PUSH   = 3'd1,
        CMD_POP    = 3'd2,
        CMD_DUP    = 3'd3,
        CMD_UNARY  = 3'd4,
        CMD_BINARY = 3'd5,
        CMD_RSV6   = 3'd6,
        CMD_RSV7   = 3'd7
    } stk_cmd_e;

    typedef enum logic [1:0] {
        TSEL_KEEP = 2'd0,
        TSEL_EXT  = 2'd1,
        TSEL_ALU  = 2'd2,
        TSEL_NOS  = 2'd3
    } tos_sel_e;

    typedef enum logic [1:0] {
        NSEL_KEEP = 2'd0,
        NSEL_TOS  = 2'd1,
        NSEL_RAM  = 2'd2
    } nos_sel_e;

    typedef enum logic [1:0] {
        PTR_KEEP = 2'd0,
        PTR_INC  = 2'd1,
        PTR_DEC  = 2'd2
    } ptr_op_e;

    typedef struct packed {
        tos_sel_e tsel;
        nos_sel_e nsel;
        ptr_op_e  pop;
        logic     spill;
        logic     ovf;
        logic     unf;
    } stk_act_t;

    // Map a command plus the current full/empty state onto a datapath action.
    function automatic stk_act_t stk_decode(stk_cmd_e c, logic full, logic empty);
        stk_act_t r;
        r.tsel  = TSEL_KEEP;
        r.nsel  = NSEL_KEEP;
        r.pop   = PTR_KEEP;
        r.spill = 1'b0;
        r.ovf   = 1'b0;
        r.unf   = 1'b0;
        case (c)
            CMD_PUSH: begin
                if (full) r.ovf = 1'b1;
                else begin
                    r.tsel  = TSEL_EXT;
                    r.nsel  = NSEL_TOS;
                    r.pop   = PTR_INC;
                    r.spill = 1'b1;
                end
            end
            CMD_DUP: begin
                if (full) r.ovf = 1'b1;
                else begin
                    r.nsel  = NSEL_TOS;
                    r.pop   = PTR_INC;
                    r.spill = 1'b1;
                end
            end
            CMD_POP: begin
                if (empty) r.unf = 1'b1;
                else begin
                    r.tsel = TSEL_NOS;
                    r.nsel = NSEL_RAM;
                    r.pop  = PTR_DEC;
                end
            end
            CMD_BINARY: begin
                if (empty) r.unf = 1'b1;
                else begin
                    r.tsel = TSEL_ALU;
                    r.nsel = NSEL_RAM;
                    r.pop  = PTR_DEC;
                end
            end
            CMD_UNARY: r.tsel = TSEL_ALU;
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic [PTR_W-1:0] sp,
    output stk_act_t         act,
    output logic [PTR_W-1:0] waddr,
    output logic [PTR_W-1:0] raddr
);
    // Empty sentinel is all ones; the last usable slot sits just below it.
    localparam logic [PTR_W-1:0] SP_EMPTY = '1;
    localparam logic [PTR_W-1:0] SP_FULL  = SP_EMPTY - PTR_W'(1);

    logic full;
    logic empty;

    always_comb begin
        full  = (sp == SP_FULL);
        empty = (sp == SP_EMPTY);
        act   = stk_decode(stk_cmd_e'(cmd), full, empty);
        waddr = sp + PTR_W'(1);
        raddr = sp;
    end

endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/stk_regs.sv
module stk_regs
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_act_t          act,
    input  logic [DATA_W-1:0] push_data,
    input  logic [DATA_W-1:0] alu_result,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos,
    output logic [PTR_W-1:0]  sp,
    output logic              ovf,
    output logic              unf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tos <= '0;
            nos <= '0;
            sp  <= '1;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            case (act.tsel)
                TSEL_EXT: tos <= push_data;
                TSEL_ALU: tos <= alu_result;
                TSEL_NOS: tos <= nos;
                default:  tos <= tos;
            endcase
            case (act.nsel)
                NSEL_TOS: nos <= tos;
                NSEL_RAM: nos <= rd_data;
                default:  nos <= nos;
            endcase
            case (act.pop)
                PTR_INC: sp <= sp + PTR_W'(1);
                PTR_DEC: sp <= sp - PTR_W'(1);
                default: sp <= sp;
            endcase
            ovf <= act.ovf;
            unf <= act.unf;
        end
    end

endmodule

// File: rtl/stk_cache_core.sv
module stk_cache_core
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] push_data,
    input  logic [DATA_W-1:0] alu_result,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos,
    output logic [PTR_W-1:0]  sp,
    output logic              ovf,
    output logic              unf,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [PTR_W-1:0]  ram_raddr
);
    stk_act_t          act;
    logic [DATA_W-1:0] rd_data;

    stk_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .cmd   (cmd),
        .sp    (sp),
        .act   (act),
        .waddr (ram_waddr),
        .raddr (ram_raddr)
    );

    // The spilled word is always the outgoing second entry.
    assign ram_we    = act.spill;
    assign ram_wdata = nos;

    stk_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (rd_data)
    );

    stk_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .push_data  (push_data),
        .alu_result (alu_result),
        .rd_data    (rd_data),
        .tos        (tos),
        .nos        (nos),
        .sp         (sp),
        .ovf        (ovf),
        .unf        (unf)
    );

endmodule

// File: rtl/stk_cache_core_chk.sv
module stk_cache_core_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd,
    input logic [DATA_W-1:0] push_data,
    input logic [DATA_W-1:0] alu_result,
    input logic [DATA_W-1:0] tos,
    input logic [DATA_W-1:0] nos,
    input logic [PTR_W-1:0]  sp,
    input logic              ovf,
    input logic              unf,
    input logic              ram_we,
    input logic [PTR_W-1:0]  ram_waddr,
    input logic [DATA_W-1:0] ram_wdata,
    input logic [PTR_W-1:0]  ram_raddr
);
    localparam logic [PTR_W-1:0] EMPTY_P = '1;
    localparam logic [PTR_W-1:0] FULL_P  = EMPTY_P - PTR_W'(1);

    logic grows, shrinks, at_full, at_empty, idle;
    assign grows    = (cmd == 3'd1) || (cmd == 3'd3);
    assign shrinks  = (cmd == 3'd2) || (cmd == 3'd5);
    assign at_full  = (sp == FULL_P);
    assign at_empty = (sp == EMPTY_P);
    assign idle     = (cmd == 3'd0) || (cmd == 3'd6) || (cmd == 3'd7);

    a_r2_push_shift: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1 && !at_full) |=> (tos == $past(push_data) && nos == $past(tos)
                                       && sp == $past(sp) + PTR_W'(1)));

    a_r2_push_spill: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1 && !at_full) |-> (ram_we && ram_waddr == sp + PTR_W'(1) && ram_wdata == nos));

    a_r3_pop_shift: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2 && !at_empty) |=> (tos == $past(nos) && sp == $past(sp) - PTR_W'(1)));

    a_r4_dup: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd3 && !at_full) |=> (tos == $past(tos) && nos == $past(tos)
                                       && sp == $past(sp) + PTR_W'(1)));

    a_r5_unary: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd4) |=> (tos == $past(alu_result) && $stable(nos) && $stable(sp)));

    a_r6_binary: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd5 && !at_empty) |=> (tos == $past(alu_result) && sp == $past(sp) - PTR_W'(1)));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        idle |=> ($stable(tos) && $stable(nos) && $stable(sp)));

    a_r7_hold_no_write: assert property (@(posedge clk) disable iff (rst)
        idle |-> !ram_we);

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (grows && at_full) |-> !ram_we);

    a_r8_ovf_flag: assert property (@(posedge clk) disable iff (rst)
        (grows && at_full) |=> (ovf && $stable(sp) && $stable(tos) && $stable(nos)));

    a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (shrinks && at_empty) |=> (unf && $stable(sp) && $stable(tos) && $stable(nos)));

    a_r9_flags_quiet: assert property (@(posedge clk) disable iff (rst)
        !((grows && at_full) || (shrinks && at_empty)) |=> (!ovf && !unf));

    a_r10_read_follows_ptr: assert property (@(posedge clk) disable iff (rst)
        ram_raddr == sp);

endmodule

bind stk_cache_core stk_cache_core_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .push_data  (push_data),
    .alu_result (alu_result),
    .tos        (tos),
    .nos        (nos),
    .sp         (sp),
    .ovf        (ovf),
    .unf        (unf),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata),
    .ram_raddr  (ram_raddr)
);

// File: tb/stk_cache_core_tb.sv
`timescale 1ns/1ps
module stk_cache_core_tb;

    localparam int DW    = 16;
    localparam int DEPTH = 256;
    localparam int PW    = 8;
    localparam int CAP   = DEPTH - 1;   // usable spill slots

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cmd = 3'd0;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] alu_result = '0;
    logic [DW-1:0] tos, nos, ram_wdata;
    logic [PW-1:0] sp, ram_waddr, ram_raddr;
    logic          ovf, unf, ram_we;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Reference model state
    int unsigned m_a = 0;
    int unsigned m_b = 0;
    logic [DW-1:0] m_spill[$];
    bit m_ovf = 0;
    bit m_unf = 0;

    always #2.5 clk = ~clk;

    stk_cache_core u_dut (
        .clk(clk), .rst(rst), .cmd(cmd), .push_data(push_data), .alu_result(alu_result),
        .tos(tos), .nos(nos), .sp(sp), .ovf(ovf), .unf(unf),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .ram_raddr(ram_raddr)
    );

    task automatic chk(string tag, string what, int unsigned act, int unsigned exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned m_sp();
        return (m_spill.size() + DEPTH - 1) % DEPTH;
    endfunction

    function automatic string tag_of(int c);
        bit full = (m_spill.size() == CAP);
        bit empty = (m_spill.size() == 0);
        case (c)
            1: return full ? "R8" : "R2";
            2: return empty ? "R9" : "R3";
            3: return full ? "R8" : "R4";
            4: return "R5";
            5: return empty ? "R9" : "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_state(string tag);
        chk(tag, "tos", tos, m_a);
        chk(tag, "nos", nos, m_b);
        chk(tag, "sp", sp, m_sp());
        chk(tag, "ovf", ovf, m_ovf);
        chk(tag, "unf", unf, m_unf);
        chk("R10", "ram_raddr", ram_raddr, m_sp());
    endtask

    // Apply one command at the falling edge, check write port, then the state after the edge.
    task automatic step(int c, int unsigned d, int unsigned alu);
        string tag;
        bit full, empty, we_exp;
        tag   = tag_of(c);
        full  = (m_spill.size() == CAP);
        empty = (m_spill.size() == 0);
        cmd = 3'(c);
        push_data = DW'(d);
        alu_result = DW'(alu);
        #1;
        we_exp = ((c == 1) || (c == 3)) && !full;
        chk(tag, "ram_we", ram_we, we_exp);
        if (we_exp) begin
            chk(tag, "ram_waddr", ram_waddr, m_spill.size() % DEPTH);
            chk(tag, "ram_wdata", ram_wdata, m_b);
        end
        m_ovf = 0;
        m_unf = 0;
        case (c)
            1: if (full) m_ovf = 1;
               else begin m_spill.push_back(DW'(m_b)); m_b = m_a; m_a = d & 16'hFFFF; end
            2: if (empty) m_unf = 1;
               else begin m_a = m_b; m_b = m_spill.pop_back(); end
            3: if (full) m_ovf = 1;
               else begin m_spill.push_back(DW'(m_b)); m_b = m_a; end
            4: m_a = alu & 16'hFFFF;
            5: if (empty) m_unf = 1;
               else begin m_a = alu & 16'hFFFF; m_b = m_spill.pop_back(); end
            default: ;
        endcase
        @(negedge clk);
        check_state(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "tos", tos, 0);
        chk("R1", "nos", nos, 0);
        chk("R1", "sp", sp, 255);
        chk("R1", "ovf", ovf, 0);
        chk("R1", "unf", unf, 0);
        chk("R1", "ram_we", ram_we, 0);
        @(negedge clk);

        // R2 pushes, R4 dup, R5 unary, R6 binary, R3 pops
        step(1, 16'h1234, 0);
        step(1, 16'hABCD, 0);
        step(1, 16'h00FF, 0);
        step(3, 0, 0);
        step(4, 0, 16'h5A5A);
        step(5, 0, 16'hC3C3);
        step(0, 16'hFFFF, 16'hFFFF);
        step(6, 16'h1111, 16'h2222);
        step(7, 16'h3333, 16'h4444);
        step(2, 0, 0);
        step(2, 0, 0);
        step(2, 0, 0);
        // R9: underflow on pop and binary, then flag clears
        for (int k = 0; k < 3; k++) step(2, 0, 0);
        step(5, 0, 16'h7777);
        step(0, 0, 0);

        // R8: fill to capacity, overflow by push and dup, flag clears on hold
        for (int k = 0; k < CAP + 3; k++) step(1, (k * 16'h0103 + 7) & 16'hFFFF, 0);
        step(3, 0, 0);
        step(0, 0, 0);
        step(4, 0, 16'hBEEF);
        // R10: unwind, LIFO order returns via nos
        for (int k = 0; k < CAP + 3; k++) step(((k % 4) == 0) ? 5 : 2, 0, k & 16'hFFFF);

        // Mixed traffic
        for (int k = 0; k < 600; k++)
            step(((k % 9) < 4) ? 1 : int'($urandom_range(0, 7)),
                 $urandom_range(0, 65535), $urandom_range(0, 65535));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule